// File: doc/BRIEF.md
# Register transfer and exchange sequencer

This block is the multi-cycle control and storage for moving values between the registers of a small 8/16-bit processor core. It holds a register file of 16-bit and 8-bit registers, a 16-bit holding register, and a cycle counter. It carries out two operations. A transfer copies a source register into a destination register. An exchange swaps two registers. Each operation is named by a pair of 4-bit register codes.

The operation begins on a start pulse and ends with a one-cycle done pulse. Two cycles of fetch slack come first. After them, every move takes a phase of two cycles, and each phase commits its write on the clock edge that closes the phase. A mode input picks standard or fast timing, and fast timing is always two cycles shorter. A simple load port lets the surrounding core preset registers while the unit is idle. A combinational observe port reads any register by its code.

Top module: `xchg_seq_unit`

## Requirements
- R1: While reset is asserted, every 16-bit register is cleared to 0 and every 8-bit register to 0. busy and done are low.
- R2: While idle, a cycle with load_en high writes load_data into the register named by load_code, and the new value can be read in the next cycle. While busy, load_en has no effect.
- R3: Register codes use this encoding:
  - Bit 3 = 0 selects 16-bit register bits[2:0], where indices 0 to 5 exist.
  - Bit 3 = 1 selects 8-bit register bits[2:0], where indices 0 to 3 exist.
  - Any other code reads as 0xFFFF, and a write to it is dropped.
- R4: Standard transfer (op_swap=0, fast_mode=0) has these properties:
  - busy is high for cycles 1 to 6 after the start edge.
  - done is high only in cycle 6.
  - The destination takes the source value on the edge that ends cycle 6.
  - No other register changes.
- R5: Standard exchange (op_swap=1, fast_mode=0) lasts 8 cycles, with done in cycle 8. The source takes the old destination value at the end of cycle 6, so the new value shows from cycle 7. The destination takes the old source value at the end of cycle 8.
- R6: Fast transfer lasts 4 cycles, with done in cycle 4. The destination takes the source value at the end of cycle 4.
- R7: Fast exchange lasts 6 cycles, with done in cycle 6. Both registers take their new values together at the end of cycle 6.
- R8: Every move carries 16 bits, so the cycle count does not depend on register widths. An 8-bit register is read as 0xFF in the high byte above its value, and an 8-bit register that is written keeps the low byte.
- R9: A start that arrives while busy is ignored, including in the done cycle. The operation, the codes and the mode are sampled only when a start is accepted.
- R10: No register value changes in cycles 1 to 4 of any operation.
- R11: When the source and destination codes are equal, the operation still runs its full length and leaves that register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| op_swap | input | 1 | 0 = transfer, 1 = exchange |
| fast_mode | input | 1 | 1 = shortened timing |
| src_code | input | 4 | Source (first) register code |
| dst_code | input | 4 | Destination (second) register code |
| load_en | input | 1 | Preset write strobe, honoured only when idle |
| load_code | input | 4 | Register code for the preset write |
| load_data | input | 16 | Preset write data |
| obs_code | input | 4 | Register code to observe |
| obs_data | output | 16 | Value of the observed register, as read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | High in the last cycle of an operation |

## Verification
Cycle 1 is the cycle that follows the clock edge that accepts start. A result committed at the end of cycle N first shows on obs_data in cycle N+1. The cycle in which the unit returns to idle counts as cycle N+1. The bench samples every output at the falling edge, and it records obs_data and done in each of cycles 1 to 11. It then compares these recordings with expectations:
- the done position with the expected length;
- the last cycle before each commit with the old value;
- the first cycle after each commit with the new value.

For a standard exchange, the intermediate commit of the source is checked between cycles 6 and 7. Start and load pulses injected in mid-run cycles are judged by the operation length and by the register contents that follow.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

    localparam int CODE_W      = 4;
    localparam int DATA_W      = 16;
    localparam int NARROW_W    = 8;
    localparam int FETCH_CYC   = 2;
    localparam int PHASE_CYC   = 2;
    localparam int XFER_PHASES = 2;
    localparam int SWAP_PHASES = 3;
    localparam int MAX_LEN     = FETCH_CYC + PHASE_CYC * SWAP_PHASES;
    localparam int CYC_W       = $clog2(MAX_LEN + 1);

    typedef enum logic {
        OP_XFER = 1'b0,
        OP_SWAP = 1'b1
    } op_e;

    typedef struct packed {
        logic              busy;
        logic [CYC_W-1:0]  cyc;
        op_e               op;
        logic              fast;
        logic [CODE_W-1:0] src;
        logic [CODE_W-1:0] dst;
    } seq_state_t;

    function automatic logic [CYC_W-1:0] op_len(input op_e op, input logic fast);
        int phases;
        phases = (op == OP_SWAP) ? SWAP_PHASES : XFER_PHASES;
        if (fast) phases = phases - 1;
        return CYC_W'(FETCH_CYC + PHASE_CYC * phases);
    endfunction

endpackage

// File: rtl/xchg_regfile.sv
module xchg_regfile
    import xchg_pkg::*;
#(
    parameter int NUM_WIDE   = 6,
    parameter int NUM_NARROW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w0_en,
    input  logic [CODE_W-1:0] w0_code,
    input  logic [DATA_W-1:0] w0_data,
    input  logic              w1_en,
    input  logic [CODE_W-1:0] w1_code,
    input  logic [DATA_W-1:0] w1_data,
    input  logic [CODE_W-1:0] ra_code,
    output logic [DATA_W-1:0] ra_data,
    input  logic [CODE_W-1:0] rb_code,
    output logic [DATA_W-1:0] rb_data
);

    localparam int IDX_W = CODE_W - 1;
    localparam int PAD_W = DATA_W - NARROW_W;

    logic [NUM_WIDE-1:0][DATA_W-1:0]     wide_bus;
    logic [NUM_NARROW-1:0][NARROW_W-1:0] narrow_bus;

    // 16-bit registers: port 1 has priority over port 0
    for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide
        localparam logic [CODE_W-1:0] MY_CODE = CODE_W'(g);
        logic [DATA_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (w0_en && w0_code == MY_CODE) val_d = w0_data;
            if (w1_en && w1_code == MY_CODE) val_d = w1_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign wide_bus[g] = val_q;
    end

    // 8-bit registers keep the low byte of a 16-bit write
    for (genvar g = 0; g < NUM_NARROW; g++) begin : g_narrow
        localparam logic [CODE_W-1:0] MY_CODE = CODE_W'(g) | CODE_W'(1 << IDX_W);
        logic [NARROW_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (w0_en && w0_code == MY_CODE) val_d = w0_data[NARROW_W-1:0];
            if (w1_en && w1_code == MY_CODE) val_d = w1_data[NARROW_W-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign narrow_bus[g] = val_q;
    end

    function automatic logic [DATA_W-1:0] lookup(
        input logic [CODE_W-1:0]                 code,
        input logic [NUM_WIDE-1:0][DATA_W-1:0]   wb,
        input logic [NUM_NARROW-1:0][NARROW_W-1:0] nb
    );
        logic [DATA_W-1:0] res;
        res = '1;
        if (!code[CODE_W-1]) begin
            for (int i = 0; i < NUM_WIDE; i++)
                if (code[IDX_W-1:0] == IDX_W'(i)) res = wb[i];
        end else begin
            for (int i = 0; i < NUM_NARROW; i++)
                if (code[IDX_W-1:0] == IDX_W'(i)) res = {{PAD_W{1'b1}}, nb[i]};
        end
        return res;
    endfunction

    always_comb begin
        ra_data = lookup(ra_code, wide_bus, narrow_bus);
        rb_data = lookup(rb_code, wide_bus, narrow_bus);
    end

endmodule

// File: rtl/xchg_move_path.sv
module xchg_move_path
    import xchg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              from_temp,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] temp_q,
    output logic [DATA_W-1:0] move_data
);

    logic [DATA_W-1:0] temp_d;

    always_comb begin
        temp_d    = cap_en ? rd_data : temp_q;
        move_data = from_temp ? temp_q : rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) temp_q <= '0;
        else        temp_q <= temp_d;
    end

endmodule

// File: rtl/xchg_phase_ctl.sv
module xchg_phase_ctl
    import xchg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_swap,
    input  logic              fast_mode,
    input  logic [CODE_W-1:0] src_code,
    input  logic [CODE_W-1:0] dst_code,
    output logic              busy,
    output logic              done,
    output logic              cap_en,
    output logic              w0_en,
    output logic [CODE_W-1:0] w0_code,
    output logic              w0_from_temp,
    output logic              w1_en,
    output logic [CODE_W-1:0] w1_code,
    output logic [CODE_W-1:0] rd_code
);

    seq_state_t st_d, st_q;

    always_comb begin
        logic [CYC_W-1:0] len;
        int               rel;
        int               ph;
        logic             phase_end;

        st_d         = st_q;
        cap_en       = 1'b0;
        w0_en        = 1'b0;
        w0_code      = st_q.dst;
        w0_from_temp = 1'b0;
        w1_en        = 1'b0;
        w1_code      = st_q.dst;

        len       = op_len(st_q.op, st_q.fast);
        done      = st_q.busy && (st_q.cyc == len);
        busy      = st_q.busy;
        rel       = int'(st_q.cyc) - FETCH_CYC;
        ph        = rel / PHASE_CYC;
        phase_end = st_q.busy && (rel > 0) && ((rel % PHASE_CYC) == 0);

        // the first-register read moves to the second register after phase 1 of an exchange
        rd_code = (st_q.op == OP_SWAP && rel > PHASE_CYC) ? st_q.dst : st_q.src;

        if (phase_end) begin
            case ({st_q.op, st_q.fast})
                {OP_XFER, 1'b0}: begin
                    if (ph == 1) cap_en = 1'b1;
                    if (ph == 2) begin
                        w0_en        = 1'b1;
                        w0_code      = st_q.dst;
                        w0_from_temp = 1'b1;
                    end
                end
                {OP_XFER, 1'b1}: begin
                    if (ph == 1) begin
                        w0_en   = 1'b1;
                        w0_code = st_q.dst;
                    end
                end
                {OP_SWAP, 1'b0}: begin
                    if (ph == 1) cap_en = 1'b1;
                    if (ph == 2) begin
                        w0_en   = 1'b1;
                        w0_code = st_q.src;
                    end
                    if (ph == 3) begin
                        w1_en   = 1'b1;
                        w1_code = st_q.dst;
                    end
                end
                default: begin
                    if (ph == 1) cap_en = 1'b1;
                    if (ph == 2) begin
                        w0_en   = 1'b1;
                        w0_code = st_q.src;
                        w1_en   = 1'b1;
                        w1_code = st_q.dst;
                    end
                end
            endcase
        end

        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cyc  = CYC_W'(1);
                st_d.op   = op_e'(op_swap);
                st_d.fast = fast_mode;
                st_d.src  = src_code;
                st_d.dst  = dst_code;
            end
        end else if (done) begin
            st_d.busy = 1'b0;
            st_d.cyc  = '0;
        end else begin
            st_d.cyc = st_q.cyc + CYC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/xchg_seq_unit.sv
module xchg_seq_unit
    import xchg_pkg::*;
#(
    parameter int NUM_WIDE   = 6,
    parameter int NUM_NARROW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_swap,
    input  logic              fast_mode,
    input  logic [CODE_W-1:0] src_code,
    input  logic [CODE_W-1:0] dst_code,
    input  logic              load_en,
    input  logic [CODE_W-1:0] load_code,
    input  logic [DATA_W-1:0] load_data,
    input  logic [CODE_W-1:0] obs_code,
    output logic [DATA_W-1:0] obs_data,
    output logic              busy,
    output logic              done
);

    logic              cap_en, w0_en, w0_from_temp, w1_en;
    logic [CODE_W-1:0] w0_code, w1_code, rd_code;
    logic [DATA_W-1:0] rd_data, temp_q, move_data;
    logic              pw_en;
    logic [CODE_W-1:0] pw_code;
    logic [DATA_W-1:0] pw_data;
    logic              load_ok;

    xchg_phase_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .op_swap      (op_swap),
        .fast_mode    (fast_mode),
        .src_code     (src_code),
        .dst_code     (dst_code),
        .busy         (busy),
        .done         (done),
        .cap_en       (cap_en),
        .w0_en        (w0_en),
        .w0_code      (w0_code),
        .w0_from_temp (w0_from_temp),
        .w1_en        (w1_en),
        .w1_code      (w1_code),
        .rd_code      (rd_code)
    );

    xchg_move_path u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .from_temp (w0_from_temp),
        .rd_data   (rd_data),
        .temp_q    (temp_q),
        .move_data (move_data)
    );

    // preset writes share port 0 and are accepted only while idle
    always_comb begin
        load_ok = load_en && !busy;
        pw_en   = w0_en || load_ok;
        pw_code = load_ok ? load_code : w0_code;
        pw_data = load_ok ? load_data : move_data;
    end

    xchg_regfile #(
        .NUM_WIDE   (NUM_WIDE),
        .NUM_NARROW (NUM_NARROW)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .w0_en   (pw_en),
        .w0_code (pw_code),
        .w0_data (pw_data),
        .w1_en   (w1_en),
        .w1_code (w1_code),
        .w1_data (temp_q),
        .ra_code (rd_code),
        .ra_data (rd_data),
        .rb_code (obs_code),
        .rb_data (obs_data)
    );

endmodule

// File: rtl/xchg_seq_unit_chk.sv
module xchg_seq_unit_chk
    import xchg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              op_swap,
    input logic              fast_mode,
    input logic [CODE_W-1:0] obs_code,
    input logic [DATA_W-1:0] obs_data,
    input logic              busy,
    input logic              done
);

    logic [3:0] run_cnt;
    logic [3:0] exp_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            exp_len <= '0;
        end else if (!busy && start) begin
            run_cnt <= 4'd1;
            case ({op_swap, fast_mode})
                2'b00:   exp_len <= 4'd6;
                2'b01:   exp_len <= 4'd4;
                2'b10:   exp_len <= 4'd8;
                default: exp_len <= 4'd6;
            endcase
        end else if (busy) begin
            run_cnt <= run_cnt + 4'd1;
        end
    end

    assert_done_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_start_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == exp_len));

    assert_quiet_head_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_cnt <= 4'd3) |=>
            ((obs_code != $past(obs_code)) || (obs_data == $past(obs_data))));

endmodule

bind xchg_seq_unit xchg_seq_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_swap   (op_swap),
    .fast_mode (fast_mode),
    .obs_code  (obs_code),
    .obs_data  (obs_data),
    .busy      (busy),
    .done      (done)
);

// File: tb/xchg_seq_unit_tb.sv
`timescale 1ns/1ps
module xchg_seq_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_swap = 1'b0, fast_mode = 1'b0;
    logic [3:0]  src_code = '0, dst_code = '0;
    logic        load_en = 1'b0;
    logic [3:0]  load_code = '0;
    logic [15:0] load_data = '0;
    logic [3:0]  obs_code = '0;
    logic [15:0] obs_data;
    logic        busy, done;

    always #4 clk = ~clk;

    xchg_seq_unit u_dut (.*);

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [15:0] mw [6];
    logic [7:0]  mn [4];
    logic [15:0] tr [12];
    int dcyc, ndone, nbusy;

    typedef struct packed {
        logic       op;
        logic       fast;
        logic [3:0] src;
        logic [3:0] dst;
        logic [3:0] len;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 4'd0,  4'd1,  4'd6},  // R4
        '{1'b0, 1'b1, 4'd2,  4'd3,  4'd4},  // R6
        '{1'b1, 1'b0, 4'd4,  4'd5,  4'd8},  // R5
        '{1'b1, 1'b1, 4'd0,  4'd2,  4'd6},  // R7
        '{1'b0, 1'b0, 4'd8,  4'd9,  4'd6},  // R8 narrow to narrow
        '{1'b0, 1'b1, 4'd1,  4'd10, 4'd4},  // R8 wide to narrow
        '{1'b1, 1'b0, 4'd11, 4'd3,  4'd8},  // R8 narrow with wide
        '{1'b0, 1'b0, 4'd5,  4'd5,  4'd6},  // R11
        '{1'b1, 1'b1, 4'd9,  4'd9,  4'd6},  // R11
        '{1'b0, 1'b0, 4'd7,  4'd4,  4'd6},  // R3 source not implemented
        '{1'b0, 1'b1, 4'd2,  4'd15, 4'd4},  // R3 write dropped
        '{1'b1, 1'b0, 4'd8,  4'd10, 4'd8}   // R8 narrow swap
    };

    function automatic logic [15:0] m_rd(input logic [3:0] c);
        int i;
        i = int'(c[2:0]);
        if (!c[3]) return (i < 6) ? mw[i] : 16'hFFFF;
        return (i < 4) ? {8'hFF, mn[i]} : 16'hFFFF;
    endfunction

    function automatic void m_wr(input logic [3:0] c, input logic [15:0] v);
        int i;
        i = int'(c[2:0]);
        if (!c[3]) begin
            if (i < 6) mw[i] = v;
        end else begin
            if (i < 4) mn[i] = v[7:0];
        end
    endfunction

    function automatic void m_apply(input logic op, input logic [3:0] s, input logic [3:0] d);
        logic [15:0] a, b;
        a = m_rd(s);
        b = m_rd(d);
        if (!op) m_wr(d, a);
        else begin
            m_wr(s, b);
            m_wr(d, a);
        end
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int bad;
        int first_act;
        int first_exp;
        bad = 0;
        first_act = 0;
        first_exp = 0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            obs_code = 4'(c);
            #1;
            if (obs_data !== m_rd(4'(c))) begin
                if (bad == 0) begin
                    first_act = int'(obs_data);
                    first_exp = int'(m_rd(4'(c)));
                end
                bad++;
            end
        end
        chk(bad == 0, req, first_act, first_exp);
    endtask

    task automatic do_load(input logic [3:0] c, input logic [15:0] v);
        @(negedge clk);
        load_en = 1'b1;
        load_code = c;
        load_data = v;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // start at a falling edge; cycle 1 is the cycle after the accepting rising edge
    task automatic run_op(input logic op, input logic fast, input logic [3:0] s,
                          input logic [3:0] d, input logic [3:0] oc, input int poke);
        dcyc = 0;
        ndone = 0;
        nbusy = 0;
        @(negedge clk);
        obs_code = oc;
        op_swap = op;
        fast_mode = fast;
        src_code = s;
        dst_code = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= 11; c++) begin
            tr[c] = obs_data;
            if (done) begin
                ndone++;
                if (dcyc == 0) dcyc = c;
            end
            if (busy) nbusy++;
            if (c == poke) begin
                start = 1'b1;
                op_swap = ~op;
                fast_mode = ~fast;
                src_code = d;
                dst_code = s;
                load_en = 1'b1;
                load_code = oc;
                load_data = 16'hDEAD;
            end else begin
                start = 1'b0;
                load_en = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        load_en = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] oldv, newv;
        logic [3:0]  oc;
        string       rq;

        for (int i = 0; i < 6; i++) mw[i] = '0;
        for (int i = 0; i < 4; i++) mn[i] = '0;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 status", {busy, done}, 0);
        rst_n = 1'b1;
        check_all("R1 register file");

        // R2, R3: presets through the load port
        for (int i = 0; i < 6; i++) begin
            do_load(4'(i), 16'h1357 + 16'(i) * 16'h2222);
            m_wr(4'(i), 16'h1357 + 16'(i) * 16'h2222);
        end
        for (int i = 0; i < 4; i++) begin
            do_load(4'(8 + i), 16'hAB40 + 16'(i));
            m_wr(4'(8 + i), 16'hAB40 + 16'(i));
        end
        check_all("R2 load while idle");
        do_load(4'd6, 16'h4444);
        @(negedge clk); obs_code = 4'd6; #1;
        chk(obs_data === 16'hFFFF, "R3 unimplemented code", obs_data, 16'hFFFF);
        @(negedge clk); obs_code = 4'd9; #1;
        chk(obs_data === 16'hFF41, "R3 narrow read pad", obs_data, 16'hFF41);

        // vector table
        for (int i = 0; i < NV; i++) begin
            oc   = VEC[i].op ? VEC[i].src : VEC[i].dst;
            oldv = m_rd(oc);
            m_apply(VEC[i].op, VEC[i].src, VEC[i].dst);
            newv = m_rd(oc);
            rq = VEC[i].fast ? (VEC[i].op ? "R7" : "R6") : (VEC[i].op ? "R5" : "R4");
            run_op(VEC[i].op, VEC[i].fast, VEC[i].src, VEC[i].dst, oc, 0);
            chk(dcyc == int'(VEC[i].len), {rq, " R8 done cycle"}, dcyc, VEC[i].len);
            chk(ndone == 1 && nbusy == int'(VEC[i].len), {rq, " busy length"}, nbusy, VEC[i].len);
            chk(tr[4] === oldv, "R10 quiet head", tr[4], oldv);
            if (VEC[i].op && !VEC[i].fast) begin
                chk(tr[6] === oldv, "R5 before first commit", tr[6], oldv);
                chk(tr[7] === newv, "R5 after first commit", tr[7], newv);
            end else begin
                chk(tr[VEC[i].len] === oldv, {rq, " before commit"}, tr[VEC[i].len], oldv);
            end
            chk(tr[VEC[i].len + 1] === newv, {rq, " after commit"}, tr[VEC[i].len + 1], newv);
            check_all({rq, " R11 register file"});
        end

        // R9: start and load pulsed in cycle 3 are ignored
        oldv = m_rd(4'd1);
        m_apply(1'b0, 4'd0, 4'd1);
        newv = m_rd(4'd1);
        run_op(1'b0, 1'b0, 4'd0, 4'd1, 4'd1, 3);
        chk(dcyc == 6 && nbusy == 6, "R9 mid-run start", nbusy, 6);
        chk(tr[5] === oldv, "R2 load ignored while busy", tr[5], oldv);
        chk(tr[7] === newv, "R9 result of first op", tr[7], newv);
        check_all("R9 register file");

        // R9: start pulsed in the done cycle is ignored
        m_apply(1'b1, 4'd2, 4'd3);
        run_op(1'b1, 1'b1, 4'd2, 4'd3, 4'd3, 6);
        chk(dcyc == 6 && nbusy == 6 && ndone == 1, "R9 start in done cycle", nbusy, 6);
        check_all("R9 after done-cycle start");

        // R1: reset in the middle of an exchange
        @(negedge clk);
        op_swap = 1'b1; fast_mode = 1'b0; src_code = 4'd0; dst_code = 4'd8; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 6; i++) mw[i] = '0;
        for (int i = 0; i < 4; i++) mn[i] = '0;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 reset mid-run", {busy, done}, 0);
        rst_n = 1'b1;
        check_all("R1 cleared after mid-run reset");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule